// File: doc/BRIEF.md
# Polarity-Selectable Tri-State Phase Detector

This block compares two pulse streams, a reference stream and a loop-divider stream, and reports their phase and frequency error on one three-state error output. The output is modelled as a drive-enable and a drive level. While the enable is low, an external loop filter holds the node. Each stream sets its own pending flag on a rising edge. While exactly one flag is pending, the output is driven. The level comes from which stream fired first and from a polarity control, so the same block can serve loops whose oscillator gain has either sign.

When both flags are pending, they are cleared one clock later. During that short overlap the output is released, so two aligned streams never cause drive. A lead of k clocks gives a drive pulse of exactly k clocks, so even a single clock of error is reported and there is no dead zone.

A second edge on the stream that is already pending leaves its flag set. The output then stays driven until the other stream catches up, which pulls a loop toward the right frequency as well as the right phase. Both stream inputs pass through a synchronizer of configurable depth before edge detection. The polarity control acts on the level directly.

Top module: `pfd_tristate`

## Requirements
- R1: An active-low `rstN` clears both flags at once, without waiting for a clock edge; while it is low and afterwards, `driveEn` and `driveLevel` are 0 until a new edge arrives.
- R2: A 0-to-1 change on `refIn` or `loopIn` sets that stream's flag and is seen at the outputs SYNC_STAGES+1 clock edges after the input changes. An input held high produces no further edges.
- R3: `driveEn` is 1 exactly when one flag is set; while `driveEn` is 0, `driveLevel` is 0.
- R4: With `polarity`=0, a pending reference flag alone (loop slower or lagging) drives `driveLevel`=1, and a pending loop flag alone (loop faster or leading) drives `driveLevel`=0.
- R5: With `polarity`=1, both levels of R4 are inverted.
- R6: When both flags are set, both are cleared on the next clock edge and the output is released for that cycle. Edges arriving in the same cycle cause no drive, and a lead of k cycles gives a drive pulse of k cycles.
- R7: A repeated rising edge on the pending stream, before the other stream fires, keeps its flag set, so the output stays driven.
- R8: A rising edge that arrives in the cycle in which both flags are cleared sets its flag again and is not lost.
- R9: A change of `polarity` while `driveEn` is 1 inverts `driveLevel` at once, with no new edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference pulse stream, rising edges counted |
| loopIn | input | 1 | Loop-divider pulse stream, rising edges counted |
| polarity | input | 1 | Inverts the driven level when 1 |
| driveEn | output | 1 | 1 while the error output is driven, 0 for high impedance |
| driveLevel | output | 1 | Level driven while driveEn is 1, else 0 |

## Verification
A flag that is stuck, or that is never cleared after overlap, shows at the ports as drive that lasts past the point where the lagging stream arrives. It also shows as a missing release cycle, visible SYNC_STAGES+1 cycles after the lagging edge. A wrong clear priority drops the edge of R8, and that shows as an output that stays released when it should restart driving. A polarity or flag-selection error inverts the level in the first driven cycle. The bench compares each pulse width and level, cycle by cycle, against hand-computed waveforms.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic setRef;
    logic setLoop;
    logic clearBoth;
  } pfdStrobes_t;
endpackage

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refIn,
  input  logic        loopIn,
  input  logic        refFlag,
  input  logic        loopFlag,
  output pfdStrobes_t strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] refSync;
  logic [SYNC_STAGES-1:0] loopSync;
  logic                   refPrev;
  logic                   loopPrev;

  // synchronizer chains, one flop per stage
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          refSync[g]  <= 1'b0;
          loopSync[g] <= 1'b0;
        end else begin
          refSync[g]  <= refIn;
          loopSync[g] <= loopIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          refSync[g]  <= 1'b0;
          loopSync[g] <= 1'b0;
        end else begin
          refSync[g]  <= refSync[g-1];
          loopSync[g] <= loopSync[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev  <= 1'b0;
      loopPrev <= 1'b0;
    end else begin
      refPrev  <= refSync[LAST];
      loopPrev <= loopSync[LAST];
    end
  end

  always_comb begin
    strobes.setRef    = refSync[LAST] & ~refPrev;
    strobes.setLoop   = loopSync[LAST] & ~loopPrev;
    strobes.clearBoth = refFlag & loopFlag;
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pfdStrobes_t strobes,
  input  logic        polarity,
  output logic        refFlag,
  output logic        loopFlag,
  output logic        driveEn,
  output logic        driveLevel
);
  // a new edge wins over the clear, so no edge is lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refFlag  <= 1'b0;
      loopFlag <= 1'b0;
    end else begin
      refFlag  <= (refFlag & ~strobes.clearBoth) | strobes.setRef;
      loopFlag <= (loopFlag & ~strobes.clearBoth) | strobes.setLoop;
    end
  end

  always_comb begin
    driveEn    = refFlag ^ loopFlag;
    driveLevel = driveEn & (refFlag ^ polarity);
  end
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic loopIn,
  input  logic polarity,
  output logic driveEn,
  output logic driveLevel
);
  pfdStrobes_t strobes;
  logic        refFlag;
  logic        loopFlag;

  pfd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .refIn    (refIn),
    .loopIn   (loopIn),
    .refFlag  (refFlag),
    .loopFlag (loopFlag),
    .strobes  (strobes)
  );

  pfd_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .polarity   (polarity),
    .refFlag    (refFlag),
    .loopFlag   (loopFlag),
    .driveEn    (driveEn),
    .driveLevel (driveLevel)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk,
  input logic rstN,
  input logic polarity,
  input logic driveEn,
  input logic driveLevel,
  input logic refFlag,
  input logic loopFlag,
  input logic setRef,
  input logic setLoop
);
  a_r1_released_in_reset: assert property (@(posedge clk)
    !rstN |-> (!driveEn && !driveLevel));

  a_r2_ref_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    setRef |=> refFlag);

  a_r2_loop_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    setLoop |=> loopFlag);

  a_r6_overlap_clears: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && loopFlag && !setRef && !setLoop) |=> (!refFlag && !loopFlag && !driveEn));

  a_r7_ref_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && !loopFlag) |=> refFlag);

  a_r7_loop_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (loopFlag && !refFlag) |=> loopFlag);

  a_r9_polarity_flips_level: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && $past(driveEn) && $stable(refFlag) && $stable(loopFlag) && !$stable(polarity))
      |-> (driveLevel != $past(driveLevel)));
endmodule

bind pfd_tristate pfd_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .polarity   (polarity),
  .driveEn    (driveEn),
  .driveLevel (driveLevel),
  .refFlag    (refFlag),
  .loopFlag   (loopFlag),
  .setRef     (strobes.setRef),
  .setLoop    (strobes.setLoop)
);

// File: tb/pfd_tristate_bench.sv
module pfd_tristate_bench;
  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;
  localparam int NVEC   = 7;

  typedef struct packed {
    logic       pol;
    logic [7:0] refW;
    logic [7:0] loopW;
    logic [7:0] expEn;
    logic [7:0] expLvl;
  } vec_t;

  // bit i of a waveform is the input level in cycle i; bit i of the
  // expected fields is the output seen LAT cycles later
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'b0000_0110, 8'b0000_0110, 8'b0000_0000, 8'b0000_0000}, // R6 aligned
    '{1'b0, 8'b0000_1100, 8'b0000_0110, 8'b0000_0010, 8'b0000_0000}, // R4 loop leads
    '{1'b0, 8'b0000_0010, 8'b0000_1000, 8'b0000_0110, 8'b0000_0110}, // R4 ref leads
    '{1'b1, 8'b0000_1100, 8'b0000_0110, 8'b0000_0010, 8'b0000_0010}, // R5 loop leads
    '{1'b1, 8'b0000_0010, 8'b0000_1000, 8'b0000_0110, 8'b0000_0000}, // R5 ref leads
    '{1'b0, 8'b0010_0000, 8'b0000_1010, 8'b0001_1110, 8'b0000_0000}, // R7 double loop
    '{1'b0, 8'b0000_1010, 8'b0000_0100, 8'b1111_1010, 8'b1111_1010}  // R8 edge in clear
  };

  function automatic string vecTag(int i);
    case (i)
      0: return "R6 aligned edges";
      1: return "R4 loop leads pol0";
      2: return "R4 ref leads pol0";
      3: return "R5 loop leads pol1";
      4: return "R5 ref leads pol1";
      5: return "R7 repeated loop edge";
      default: return "R8 edge during clear";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic loopIn = 1'b0;
  logic polarity = 1'b0;
  logic driveEn;
  logic driveLevel;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pfd_tristate #(.SYNC_STAGES(STAGES)) u_pfd_tristate (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .loopIn     (loopIn),
    .polarity   (polarity),
    .driveEn    (driveEn),
    .driveLevel (driveLevel)
  );

  task automatic check(string tag, logic en, logic lvl);
    checks++;
    if (driveEn !== en || driveLevel !== lvl) begin
      errors++;
      $display("FAIL %s: got en=%b lvl=%b, expected en=%b lvl=%b",
               tag, driveEn, driveLevel, en, lvl);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    refIn = 1'b0;
    loopIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    doReset();
    #1 check("R1 reset state", 1'b0, 1'b0);

    // table of waveforms
    for (int v = 0; v < NVEC; v++) begin
      polarity = VECS[v].pol;
      doReset();
      for (int k = 0; k < 8 + LAT; k++) begin
        if (k > 0) @(negedge clk);
        if (k >= LAT)
          check(vecTag(v), VECS[v].expEn[k-LAT], VECS[v].expLvl[k-LAT]);
        refIn  = (k < 8) ? VECS[v].refW[k] : 1'b0;
        loopIn = (k < 8) ? VECS[v].loopW[k] : 1'b0;
      end
    end

    // R2 and R3: latency, and a held-high input gives no second edge
    polarity = 1'b0;
    doReset();
    refIn = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    check("R2 before latency", 1'b0, 1'b0);
    @(negedge clk);
    check("R2 at latency", 1'b1, 1'b1);
    loopIn = 1'b1;
    repeat (LAT + 4) @(negedge clk);
    check("R2 held high no re-arm", 1'b0, 1'b0);

    // R9: polarity flip during drive
    doReset();
    refIn = 1'b1;
    repeat (LAT) @(negedge clk);
    check("R9 before flip", 1'b1, 1'b1);
    polarity = 1'b1;
    #1 check("R9 after flip", 1'b1, 1'b0);
    polarity = 1'b0;
    #1 check("R9 flip back", 1'b1, 1'b1);

    // R1: asynchronous reset while driving
    @(negedge clk);
    rstN = 1'b0;
    #1 check("R1 async release", 1'b0, 1'b0);
    refIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (LAT + 1) @(negedge clk);
    check("R1 stays released", 1'b0, 1'b0);

    finish();
  end
endmodule